// File: doc/BRIEF.md
# Slot-Map Record Store Manager

This block keeps the index of a slot-based error-record store. A small table holds one 64-bit record identifier per storage slot, where zero marks a free slot. A 32-bit register holds the number of valid records. The block does not move record data. It answers where a record lives, where a new record should go, whether a record can be removed, and which identifier comes next when software walks the store. The host register layer and the data mover sit outside it.

A caller presents an operation code and an identifier with a one-cycle `start`. The block then walks the table one entry per clock, raises `done` for one cycle, and returns a status code, a slot index and an identifier. The slots below the first-record index hold the storage header and are never handed out. A persistent cursor lets repeated get-next requests list every stored identifier in slot order. The list ends with the all-ones identifier.

Operation codes on `op`: 0 write, 1 read, 2 clear, 3 get-next, 4 get-first, 5 to 7 unused.
Status codes: 0x00 success, 0x01 no space, 0x03 failed, 0x04 store empty, 0x05 not found.

Top module: `slot_map_mgr`

## Requirements
- R1: A write or clear whose identifier is 0 or all ones finishes with status 0x03 and changes neither the table nor the count. The all-ones value is never stored.
- R2: Usable slots run from HDR_BYTES/REC_BYTES (2 by default) up to, but not including, STORE_BYTES/REC_BYTES (16). Any nonzero slot returned lies in that range.
- R3: A write of an identifier already stored returns status 0x00 and that same slot, and leaves the count unchanged.
- R4: A write of a new identifier takes the lowest free slot, returns 0x00 with that slot, and adds one to the count. When no slot is free it returns 0x01, slot 0, and the count is unchanged.
- R5: A clear of a stored identifier returns 0x00 with its slot, frees the slot for reuse and subtracts one from the count. A clear of an absent identifier returns 0x05.
- R6: A read with count 0 returns 0x04. A read with identifier 0 returns the lowest occupied slot and its identifier, and moves the cursor past that slot. A read with all ones returns 0x03. A read of a stored identifier returns 0x00 and its slot.
- R7: A read of an absent identifier returns 0x05, slot 0, and resets the cursor to the first usable slot.
- R8: Get-next returns status 0x00 and the first occupied slot at or after the cursor, with its identifier, and moves the cursor past it. When nothing is left it returns all ones and slot 0, and resets the cursor. Get-first resets the cursor before it searches.
- R9: A lookup visits one slot per clock from the first usable slot. It stops on a match, at the end of the table, or once it has passed as many occupied slots as the count. A miss therefore finishes after the last stored record, not at the table end.
- R10: `busy` is high from the cycle after an accepted start until `done`. A `start` seen while busy is ignored. `done` is a single-cycle pulse, and `busy` is low while it is high.
- R11: After reset the count, `done`, `busy`, `status`, `slot` and `id_out` are all zero, and every table entry is free.
- R12: Operation codes 5 to 7 finish in the cycle after `start` with status 0x03 and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code |
| id_in | input | ID_W (64) | Record identifier argument |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Completion status code |
| slot | output | IW (5) | Slot index of the result, 0 if none |
| id_out | output | ID_W (64) | Resulting identifier |
| rec_count | output | 32 | Number of valid records |

## Verification
Writes are tried on an empty store, on an identifier already present, on slots freed by an earlier clear, and on a full table. These cases separate the overwrite, allocate and no-space paths, and show whether freed slots are reused lowest-first. Lookups that miss are issued with records packed at the bottom of the table, so a scan that runs to the end finishes late and is flagged by the completion timing. Cursor walks span the last record, the wrap to the all-ones marker, a reset caused by a missing read, and a reset caused by get-first. A second start is injected mid-scan to show that it is dropped.

// File: rtl/smm_pkg.sv
// Shared encodings for the slot-map record store manager.
// Assumes 3-bit operation codes and 8-bit status codes.
package smm_pkg;
    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_READ  = 3'd1,
        OP_CLEAR = 3'd2,
        OP_NEXT  = 3'd3,
        OP_FIRST = 3'd4
    } smm_op_e;

    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ST_NOSPACE  = 8'h01;
    localparam logic [7:0] ST_FAILED   = 8'h03;
    localparam logic [7:0] ST_EMPTY    = 8'h04;
    localparam logic [7:0] ST_NOTFOUND = 8'h05;
endpackage

// File: rtl/smm_map_ram.sv
// Slot table: one identifier per slot, zero means free.
// Combinational read port and one synchronous write port.
// Assumes writes only target usable slots; header slots stay zero.
module smm_map_ram #(
    parameter int SLOTS     = 16,
    parameter int ID_W      = 64,
    parameter int IW        = 5,
    parameter int FIRST_IDX = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_addr,
    output logic [ID_W-1:0] rd_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_addr,
    input  logic [ID_W-1:0] wr_data
);
    localparam int AW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [ID_W-1:0] mem [SLOTS];

    // Table storage: cleared on reset, updated by the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else if (wr_en && (wr_addr < IW'(SLOTS))) begin
            mem[wr_addr[AW-1:0]] <= wr_data;
        end
    end

    // Read port: addresses past the table read as free.
    always_comb begin
        rd_data = (rd_addr < IW'(SLOTS)) ? mem[rd_addr[AW-1:0]] : '0;
    end

    assert_wr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= IW'(FIRST_IDX) && wr_addr < IW'(SLOTS)));
    assert_wr_not_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data != '1));
endmodule

// File: rtl/smm_rec_counter.sv
// Valid-record counter with increment and decrement strobes.
// Assumes the two strobes are never high together.
module smm_rec_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count
);
    // Count register: moves by one on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + CW'(1);
        else if (dec) count <= count - CW'(1);
    end

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0));
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (count != '1));
endmodule

// File: rtl/smm_scan_ctrl.sv
// Operation sequencer: decodes a started operation and scans the table
// one slot per clock for lookup, free-slot search or cursor walk.
// Assumes the table read port is combinational on rd_addr.
module smm_scan_ctrl
    import smm_pkg::*;
#(
    parameter int ID_W      = 64,
    parameter int IW        = 5,
    parameter int FIRST_IDX = 2,
    parameter int LAST_IDX  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [ID_W-1:0] id_in,
    input  logic [31:0]     count,
    output logic [IW-1:0]   rd_addr,
    input  logic [ID_W-1:0] rd_data,
    output logic            wr_en,
    output logic [IW-1:0]   wr_addr,
    output logic [ID_W-1:0] wr_data,
    output logic            inc,
    output logic            dec,
    output logic            busy,
    output logic            done,
    output logic [7:0]      status,
    output logic [IW-1:0]   slot,
    output logic [ID_W-1:0] id_out
);
    typedef enum logic [1:0] {S_IDLE, S_LOOKUP, S_ALLOC, S_WALK} state_e;

    localparam logic [IW-1:0] FIRST  = IW'(FIRST_IDX);
    localparam logic [IW-1:0] LAST   = IW'(LAST_IDX);
    localparam logic [31:0]   USABLE = 32'(LAST_IDX - FIRST_IDX);

    state_e          st;
    logic [IW-1:0]   idx, cursor;
    logic [31:0]     seen;
    logic [2:0]      op_q;
    logic [ID_W-1:0] id_q;
    logic            stop, hit, free_here, bad_id;

    // Scan decisions for the slot currently addressed.
    always_comb begin
        stop      = (idx >= LAST) || (seen >= count);
        hit       = (st == S_LOOKUP) && !stop && (rd_data == id_q);
        free_here = (st == S_ALLOC) && (idx < LAST) && (rd_data == '0);
        bad_id    = (id_in == '0) || (id_in == '1);
        rd_addr   = idx;
        wr_addr   = idx;
        inc       = free_here;
        dec       = hit && (op_q == OP_CLEAR);
        wr_en     = inc || dec;
        wr_data   = free_here ? id_q : '0;
        busy      = (st != S_IDLE);
    end

    // Sequencer: accepts a start when idle, steps the scan, posts results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; idx <= FIRST; cursor <= FIRST; seen <= '0;
            op_q <= '0; id_q <= '0; done <= 1'b0; status <= ST_OK;
            slot <= '0; id_out <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    op_q <= op; id_q <= id_in; idx <= FIRST; seen <= '0;
                    id_out <= id_in; slot <= '0;
                    case (op)
                        OP_WRITE, OP_CLEAR:
                            if (bad_id) begin done <= 1'b1; status <= ST_FAILED; end
                            else st <= S_LOOKUP;
                        OP_READ:
                            if (count == '0) begin done <= 1'b1; status <= ST_EMPTY; end
                            else if (id_in == '0) st <= S_WALK;
                            else if (id_in == '1) begin done <= 1'b1; status <= ST_FAILED; end
                            else st <= S_LOOKUP;
                        OP_NEXT: begin idx <= cursor; st <= S_WALK; end
                        OP_FIRST: begin cursor <= FIRST; st <= S_WALK; end
                        default: begin done <= 1'b1; status <= ST_FAILED; end
                    endcase
                end
                S_LOOKUP: begin
                    if (stop) begin
                        if (op_q == OP_WRITE) begin
                            st <= S_ALLOC; idx <= FIRST;
                        end else begin
                            done <= 1'b1; status <= ST_NOTFOUND; st <= S_IDLE;
                            if (op_q == OP_READ) cursor <= FIRST;
                        end
                    end else if (rd_data == id_q) begin
                        done <= 1'b1; status <= ST_OK; slot <= idx; st <= S_IDLE;
                    end else begin
                        if (rd_data != '0) seen <= seen + 32'd1;
                        idx <= idx + IW'(1);
                    end
                end
                S_ALLOC: begin
                    if (idx >= LAST) begin
                        done <= 1'b1; status <= ST_NOSPACE; st <= S_IDLE;
                    end else if (rd_data == '0) begin
                        done <= 1'b1; status <= ST_OK; slot <= idx; st <= S_IDLE;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                S_WALK: begin
                    if (idx >= LAST) begin
                        cursor <= FIRST; done <= 1'b1; id_out <= '1; st <= S_IDLE;
                        status <= (op_q == OP_READ) ? ST_FAILED : ST_OK;
                    end else if (rd_data != '0) begin
                        cursor <= idx + IW'(1); done <= 1'b1; status <= ST_OK;
                        slot <= idx; id_out <= rd_data; st <= S_IDLE;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_cursor_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cursor >= FIRST) && (cursor <= LAST));
    assert_nospace_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_NOSPACE) |-> (count == USABLE));
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && slot != '0) |-> (slot >= FIRST && slot < LAST));
endmodule

// File: rtl/slot_map_mgr.sv
// Top of the slot-map record store manager: wires the table, the
// record counter and the scan sequencer. Geometry comes from byte sizes;
// assumes all three sizes are multiples of REC_BYTES.
module slot_map_mgr #(
    parameter int STORE_BYTES = 65536,
    parameter int REC_BYTES   = 4096,
    parameter int HDR_BYTES   = 8192,
    parameter int ID_W        = 64,
    localparam int SLOTS      = STORE_BYTES / REC_BYTES,
    localparam int FIRST_IDX  = HDR_BYTES / REC_BYTES,
    localparam int IW         = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [ID_W-1:0] id_in,
    output logic            busy,
    output logic            done,
    output logic [7:0]      status,
    output logic [IW-1:0]   slot,
    output logic [ID_W-1:0] id_out,
    output logic [31:0]     rec_count
);
    logic [IW-1:0]   rd_addr, wr_addr;
    logic [ID_W-1:0] rd_data, wr_data;
    logic            wr_en, inc, dec;

    smm_map_ram #(.SLOTS(SLOTS), .ID_W(ID_W), .IW(IW), .FIRST_IDX(FIRST_IDX)) u_ram (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    smm_rec_counter #(.CW(32)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .count(rec_count));

    smm_scan_ctrl #(.ID_W(ID_W), .IW(IW), .FIRST_IDX(FIRST_IDX), .LAST_IDX(SLOTS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .id_in(id_in),
        .count(rec_count), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inc(inc), .dec(dec), .busy(busy), .done(done), .status(status),
        .slot(slot), .id_out(id_out));
endmodule

// File: tb/tb_slot_map_mgr.sv
`timescale 1ns/1ps
module tb_slot_map_mgr;
    localparam int FIRST = 8192 / 4096;
    localparam int LAST  = 65536 / 4096;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] id_in = '0;
    logic        busy, done;
    logic [7:0]  status;
    logic [4:0]  slot;
    logic [63:0] id_out;
    logic [31:0] rec_count;

    int total = 0;
    int bad = 0;

    // Behavioural reference state
    logic [63:0] mm [0:LAST-1];
    int mcount = 0;
    int mcursor = FIRST;

    always #4 clk = ~clk;

    slot_map_mgr dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .id_in(id_in),
        .busy(busy), .done(done), .status(status), .slot(slot), .id_out(id_out),
        .rec_count(rec_count));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic m_lookup(input logic [63:0] id, output bit hit, output int hidx, output int steps);
        int i = FIRST; int seen = 0;
        hit = 0; hidx = 0; steps = 0;
        while (1) begin
            if (i >= LAST || seen >= mcount) break;
            if (mm[i] == id) begin hit = 1; hidx = i; break; end
            if (mm[i] != 0) seen++;
            i++; steps++;
        end
    endtask

    task automatic m_walk(input int from, output bit found, output int fidx, output int skips);
        int i = from;
        found = 0; fidx = 0; skips = 0;
        while (i < LAST) begin
            if (mm[i] != 0) begin found = 1; fidx = i; break; end
            i++; skips++;
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [63:0] id, input string tag,
                          input bit intrude);
        logic [7:0] es = 8'h00; int eslot = 0; logic [63:0] eid = id; int L = 0;
        int oldc = mcount; bit hit; int hidx; int steps; bit fnd; int fidx; int sk;
        case (o)
            3'd0: if (id == 0 || id == ONES) es = 8'h03;
                  else begin
                      m_lookup(id, hit, hidx, steps);
                      if (hit) begin eslot = hidx; L = 1 + steps; end
                      else begin
                          int a = 0; int i = FIRST;
                          while (i < LAST && mm[i] != 0) begin i++; a++; end
                          L = 2 + steps + a;
                          if (i < LAST) begin eslot = i; mm[i] = id; mcount++; end
                          else es = 8'h01;
                      end
                  end
            3'd1: if (mcount == 0) es = 8'h04;
                  else if (id == 0) begin
                      m_walk(FIRST, fnd, fidx, sk);
                      L = 1 + sk; eslot = fidx; eid = mm[fidx]; mcursor = fidx + 1;
                  end else if (id == ONES) es = 8'h03;
                  else begin
                      m_lookup(id, hit, hidx, steps);
                      L = 1 + steps;
                      if (hit) eslot = hidx;
                      else begin es = 8'h05; mcursor = FIRST; end
                  end
            3'd2: if (id == 0 || id == ONES) es = 8'h03;
                  else begin
                      m_lookup(id, hit, hidx, steps);
                      L = 1 + steps;
                      if (hit) begin eslot = hidx; mm[hidx] = 0; mcount--; end
                      else es = 8'h05;
                  end
            3'd3, 3'd4: begin
                  if (o == 3'd4) mcursor = FIRST;
                  m_walk(mcursor, fnd, fidx, sk);
                  L = 1 + sk;
                  if (fnd) begin eslot = fidx; eid = mm[fidx]; mcursor = fidx + 1; end
                  else begin eid = ONES; mcursor = FIRST; end
                  end
            default: es = 8'h03;
        endcase

        @(negedge clk); start = 1'b1; op = o; id_in = id;
        @(posedge clk);
        for (int n = 0; n <= L; n++) begin
            @(negedge clk);
            if (n == 0) begin
                if (intrude && L >= 1) begin start = 1'b1; op = 3'd2; id_in = 64'hA001; end
                else start = 1'b0;
            end else if (n == 1) start = 1'b0;
            chk(done == (n == L), "R9 R10", $sformatf("%s done timing n=%0d", tag, n), 64'(done), 64'(n == L));
            chk(busy == (n < L), "R10", $sformatf("%s busy n=%0d", tag, n), 64'(busy), 64'(n < L));
            chk(rec_count == ((n < L) ? oldc : mcount), tag, "count per cycle",
                64'(rec_count), 64'((n < L) ? oldc : mcount));
        end
        start = 1'b0;
        chk(status == es, tag, "status", 64'(status), 64'(es));
        chk(slot == eslot, tag, "slot", 64'(slot), 64'(eslot));
        chk(id_out == eid, tag, "id_out", id_out, eid);
        @(negedge clk);
        chk(!done && !busy, "R10", $sformatf("%s single done pulse", tag), 64'({done, busy}), 64'(0));
        chk(rec_count == mcount, tag, "count after", 64'(rec_count), 64'(mcount));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < LAST; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rec_count == 0 && !done && !busy, "R11", "reset outputs", 64'({rec_count, done, busy}), 64'(0));
        chk(status == 0 && slot == 0 && id_out == 0, "R11", "reset result regs", id_out, 64'(0));

        run_op(3'd0, 64'h0, "R1", 0);
        run_op(3'd0, ONES, "R1", 0);
        run_op(3'd1, 64'hA001, "R6", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd2, 64'hA001, "R5", 0);
        run_op(3'd0, 64'hA001, "R2 R4", 0);
        run_op(3'd0, 64'hB002, "R4", 0);
        run_op(3'd0, 64'hC003, "R4", 0);
        run_op(3'd0, 64'hA001, "R3", 0);
        run_op(3'd2, 64'hB002, "R5", 0);
        run_op(3'd0, 64'hD004, "R4", 0);
        run_op(3'd2, 64'hB002, "R5", 0);
        run_op(3'd2, 64'h0, "R1", 0);
        run_op(3'd2, ONES, "R1", 0);
        run_op(3'd2, 64'hE005, "R9", 0);
        run_op(3'd1, 64'hC003, "R6", 0);
        run_op(3'd1, 64'h0, "R6", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd1, ONES, "R6", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd1, 64'hE005, "R7", 0);
        run_op(3'd3, 64'h0, "R7", 0);
        run_op(3'd3, 64'h0, "R8", 0);
        run_op(3'd4, 64'h0, "R8", 0);
        for (int k = 5; k <= 7; k++) run_op(3'(k), 64'hA001, "R12", 0);
        run_op(3'd0, 64'hF006, "R10", 1);
        run_op(3'd1, 64'hA001, "R10", 0);
        run_op(3'd2, 64'hC003, "R5", 0);
        for (int k = 0; k < 16; k++) run_op(3'd0, 64'h100 + 64'(k), "R4", 0);
        run_op(3'd0, 64'hA001, "R3", 0);
        run_op(3'd2, 64'hBEEF, "R9", 0);
        run_op(3'd2, 64'h105, "R5", 0);
        run_op(3'd0, 64'h777, "R4", 0);
        run_op(3'd4, 64'h0, "R8", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule